// File: doc/BRIEF.md
# Configurable External Interrupt Controller

This block collects up to 32 external interrupt pins and turns each into an interrupt request for one CPU. Every pin first passes through a two-flop synchronizer. A per-line sense field then decides what counts as an event: an active-low level, an active-high level, a falling edge, a rising edge, or either edge. Edges are found by comparing the synchronized sample with the sample taken one clock earlier.

A detected event sets that line's detect bit. In edge modes the bit stays set until software writes 1 to it. In level-only modes the bit tracks the synchronized level. A per-line enable mask is changed through two write-one registers, one that sets bits and one that clears them. Each line drives its own interrupt output, which is its detect bit ANDed with its enable bit.

Software reaches the block through a simple 32-bit bus. Writes take effect on the clock edge. Reads are combinational from the address. Bit n of every per-line register belongs to line n. Addresses are byte offsets and must be word aligned.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, the enable mask, all detect bits and all sense fields are 0, and every `irq_out` bit is 0.
- R2: Writing offset 0x008 sets each enable bit whose data bit is 1, and zero bits leave the other lines unchanged. Reading offset 0x004 returns the enable mask.
- R3: Writing offset 0x004 clears each enable bit whose data bit is 1, and zero bits have no effect.
- R4: Line n's sense field sits at offset 0x180 + 4·n and keeps the low 6 bits of the written data. A read returns those bits, with bits 31:6 returned as 0. Lines that do not exist read as 0.
- R5: Sense code 0x01 detects a low level and sense code 0x02 detects a high level. In a level-only mode the detect bit follows the synchronized level, so a write-1 clear has no lasting effect while the level stays active.
- R6: Sense code 0x08 detects a rising edge, 0x04 a falling edge and 0x0C both edges. In these modes the detect bit stays set after the pin returns to its idle level.
- R7: Offset 0x100 reads the detect bits. Writing 1 to a bit clears it, and zero bits have no effect.
- R8: A line whose sense field is 0x00 never sets its detect bit, whatever its pin does.
- R9: `irq_out[n]` is detect bit n AND enable bit n, and reading offset 0x000 returns the same vector. A line that is not enabled never raises its output.
- R10: A pin change that the driver applies before clock edge k shows up in the detect register after edge k+2 (a two-flop synchronizer plus the detect flop), and not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Byte offset of the register being accessed |
| bus_wr | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq_pins | input | NUM_LINES | Asynchronous external interrupt pins |
| irq_out | output | NUM_LINES | Per-line interrupt request to the CPU |

## Verification
Each sense mode gets the pin pattern that separates it from its neighbours:
- A rising pulse in rising mode shows that the detect bit is sticky.
- A rise followed by a fall in falling mode shows that only the configured edge counts.
- Two transitions in both-edge mode, with a clear in between, show that each direction sets the bit.
- A low-then-high pin in low-level mode, with a write-1 clear while the level is still active, shows that level lines follow the pin instead of latching.

A pin toggling on a line with a zero sense field shows that no event is seen. Sampling one cycle before and at the expected edge pins down the three-cycle latency. Enabled and disabled lines are exercised side by side, which separates the masked request view from the raw detect view.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int REG_W   = 32;
  localparam int ADDR_W  = 9;
  localparam int SENSE_W = 6;
  localparam int IDX_W   = 5;

  localparam logic [ADDR_W-1:0] OFS_REQ    = 9'h000;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR = 9'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET = 9'h008;
  localparam logic [ADDR_W-1:0] OFS_DET    = 9'h100;

  // one-hot sense bit positions
  localparam int SB_LOW  = 0;
  localparam int SB_HIGH = 1;
  localparam int SB_FALL = 2;
  localparam int SB_RISE = 3;

  function automatic logic sense_hit(logic [SENSE_W-1:0] cfg, logic cur, logic prev);
    return (cfg[SB_LOW]  & ~cur)
         | (cfg[SB_HIGH] &  cur)
         | (cfg[SB_FALL] &  prev & ~cur)
         | (cfg[SB_RISE] &  cur  & ~prev);
  endfunction

  function automatic logic is_edge(logic [SENSE_W-1:0] cfg);
    return cfg[SB_FALL] | cfg[SB_RISE];
  endfunction

  function automatic logic is_level(logic [SENSE_W-1:0] cfg);
    return cfg[SB_LOW] | cfg[SB_HIGH];
  endfunction
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q   <= '0;
      sync_out <= '0;
    end else begin
      meta_q   <= async_in;
      sync_out <= meta_q;
    end
  end
endmodule

// File: rtl/ext_irq_line.sv
module ext_irq_line
  import ext_irq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync_in,
  input  logic               cfg_we,
  input  logic [SENSE_W-1:0] cfg_wdata,
  input  logic               clr,
  output logic [SENSE_W-1:0] cfg_q,
  output logic               det_q,
  output logic               hit,
  output logic               edge_mode,
  output logic               level_mode
);
  logic prev_q;

  assign hit        = sense_hit(cfg_q, sync_in, prev_q);
  assign edge_mode  = is_edge(cfg_q);
  assign level_mode = is_level(cfg_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      prev_q <= 1'b0;
      det_q  <= 1'b0;
    end else begin
      prev_q <= sync_in;
      if (cfg_we) cfg_q <= cfg_wdata;
      // a new event beats a clear in the same cycle; only edge modes hold
      det_q <= hit | (det_q & edge_mode & ~clr);
    end
  end
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic [REG_W-1:0]     bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  input  logic [NUM_LINES-1:0] irq_pins,
  output logic [NUM_LINES-1:0] irq_out
);
  logic [NUM_LINES-1:0] pin_sync;
  logic [NUM_LINES-1:0] en_q;
  logic [NUM_LINES-1:0] det_vec, hit_vec, edge_vec, level_vec;
  logic [NUM_LINES-1:0] en_set_vec, en_clr_vec, det_clr_vec;
  logic [SENSE_W-1:0]   cfg_arr [NUM_LINES];

  logic             hit_req, hit_en_clr, hit_en_set, hit_det, hit_cfg;
  logic [IDX_W-1:0] cfg_idx;

  assign hit_req    = (bus_addr == OFS_REQ);
  assign hit_en_clr = (bus_addr == OFS_EN_CLR);
  assign hit_en_set = (bus_addr == OFS_EN_SET);
  assign hit_det    = (bus_addr == OFS_DET);
  assign hit_cfg    = (bus_addr[8:7] == 2'b11) && (bus_addr[1:0] == 2'b00);
  assign cfg_idx    = bus_addr[6:2];

  assign en_set_vec  = (bus_wr && hit_en_set) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign en_clr_vec  = (bus_wr && hit_en_clr) ? bus_wdata[NUM_LINES-1:0] : '0;
  assign det_clr_vec = (bus_wr && hit_det)    ? bus_wdata[NUM_LINES-1:0] : '0;

  ext_irq_sync #(.W(NUM_LINES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_in(irq_pins), .sync_out(pin_sync)
  );

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    ext_irq_line line_i (
      .clk(clk),
      .rst_n(rst_n),
      .sync_in(pin_sync[g]),
      .cfg_we(bus_wr && hit_cfg && (cfg_idx == IDX_W'(g))),
      .cfg_wdata(bus_wdata[SENSE_W-1:0]),
      .clr(det_clr_vec[g]),
      .cfg_q(cfg_arr[g]),
      .det_q(det_vec[g]),
      .hit(hit_vec[g]),
      .edge_mode(edge_vec[g]),
      .level_mode(level_vec[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= (en_q | en_set_vec) & ~en_clr_vec;
  end

  assign irq_out = det_vec & en_q;

  always_comb begin
    bus_rdata = '0;
    if (hit_req)         bus_rdata = REG_W'(irq_out);
    else if (hit_en_clr) bus_rdata = REG_W'(en_q);
    else if (hit_det)    bus_rdata = REG_W'(det_vec);
    else if (hit_cfg && (32'(cfg_idx) < NUM_LINES))
                         bus_rdata = REG_W'(cfg_arr[cfg_idx]);
  end
endmodule

// File: rtl/ext_irq_ctrl_chk.sv
module ext_irq_ctrl_chk
  import ext_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_wr,
  input logic [REG_W-1:0]     bus_wdata,
  input logic [NUM_LINES-1:0] en_q,
  input logic [NUM_LINES-1:0] det_vec,
  input logic [NUM_LINES-1:0] hit_vec,
  input logic [NUM_LINES-1:0] edge_vec,
  input logic [NUM_LINES-1:0] level_vec
);
  logic [NUM_LINES-1:0] wmask, clr_seen, lvl_only;
  assign wmask    = bus_wdata[NUM_LINES-1:0];
  assign clr_seen = (bus_wr && bus_addr == OFS_DET) ? wmask : '0;
  assign lvl_only = level_vec & ~edge_vec;

  assert_en_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_SET) |=> ((en_q & $past(wmask)) == $past(wmask)));

  assert_en_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_EN_CLR) |=> ((en_q & $past(wmask)) == '0));

  assert_det_needs_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((det_vec & ~$past(det_vec) & ~$past(hit_vec)) == '0));

  assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(det_vec & edge_vec & ~clr_seen) & ~det_vec) == '0));

  assert_level_follow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((det_vec & $past(lvl_only)) == $past(hit_vec & lvl_only)));
endmodule

bind ext_irq_ctrl ext_irq_ctrl_chk #(.NUM_LINES(NUM_LINES)) chk_i (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .en_q(en_q), .det_vec(det_vec), .hit_vec(hit_vec),
  .edge_vec(edge_vec), .level_vec(level_vec)
);

// File: tb/ext_irq_ctrl_tb_top.sv
module ext_irq_ctrl_tb_top;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [8:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [N-1:0]  irq_pins = '0;
  logic [N-1:0]  irq_out;

  int n_checks = 0;
  int n_fail = 0;

  typedef struct {
    bit          is_irq;
    logic [31:0] exp;
    string       tag;
  } exp_item_t;

  exp_item_t exp_q[$];

  always #2 clk = ~clk;

  ext_irq_ctrl #(.NUM_LINES(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pins(irq_pins),
    .irq_out(irq_out)
  );

  // monitor: pops one expected item per cycle and compares it with the ports
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        exp_item_t it;
        logic [31:0] act;
        it = exp_q.pop_front();
        act = it.is_irq ? 32'(irq_out) : bus_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual 0x%08h expected 0x%08h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [8:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd_chk(logic [8:0] a, logic [31:0] e, string tag);
    exp_item_t it;
    @(negedge clk);
    bus_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic irq_chk(logic [31:0] e, string tag);
    exp_item_t it;
    @(negedge clk);
    it.is_irq = 1'b1; it.exp = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic set_pins(logic [N-1:0] v);
    @(negedge clk);
    irq_pins = v;
  endtask

  function automatic logic [8:0] cfg_ofs(int n);
    return 9'(9'h180 + 4 * n);
  endfunction

  bit done = 1'b0;

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;

    // R1 reset state
    rd_chk(9'h004, 32'h0, "R1 enable mask");
    rd_chk(9'h100, 32'h0, "R1 detect");
    rd_chk(cfg_ofs(0), 32'h0, "R1 sense field");
    irq_chk(32'h0, "R1 irq_out");

    // R4 sense field width and readback
    wr(cfg_ofs(9), 32'hFFFF_FFC8);
    rd_chk(cfg_ofs(9), 32'h08, "R4 upper bits dropped");
    rd_chk(cfg_ofs(10), 32'h0, "R4 untouched field");

    // R2 / R3 enable set and clear
    wr(9'h008, 32'h9);
    rd_chk(9'h004, 32'h9, "R2 set lines 0,3");
    wr(9'h008, 32'h20);
    rd_chk(9'h004, 32'h29, "R2 zero bits keep others");
    wr(9'h004, 32'h1);
    rd_chk(9'h004, 32'h28, "R3 clear line 0");

    // R8 zero sense field sees nothing
    set_pins(32'h80);
    idle(3);
    set_pins(32'h0);
    idle(3);
    rd_chk(9'h100, 32'h0, "R8 zero sense");

    // R6 / R10 rising edge on line 3
    wr(cfg_ofs(3), 32'h08);
    set_pins(32'h08);
    idle(1);
    rd_chk(9'h100, 32'h0, "R10 not yet after two edges");
    rd_chk(9'h100, 32'h08, "R10 R6 rise seen after three edges");
    irq_chk(32'h08, "R9 enabled line raises irq_out");
    rd_chk(9'h000, 32'h08, "R9 request view");
    set_pins(32'h0);
    idle(3);
    rd_chk(9'h100, 32'h08, "R6 sticky after pin falls");

    // R7 write-1-to-clear
    wr(9'h100, 32'h0);
    rd_chk(9'h100, 32'h08, "R7 zero write no effect");
    wr(9'h100, 32'h08);
    rd_chk(9'h100, 32'h0, "R7 write-1 clears");
    irq_chk(32'h0, "R9 irq_out drops with detect");

    // R6 falling edge on line 3
    wr(cfg_ofs(3), 32'h04);
    set_pins(32'h08);
    idle(3);
    rd_chk(9'h100, 32'h0, "R6 rise ignored in falling mode");
    set_pins(32'h0);
    idle(3);
    rd_chk(9'h100, 32'h08, "R6 fall detected");
    wr(9'h100, 32'h08);

    // R6 both edges on disabled line 1
    wr(cfg_ofs(1), 32'h0C);
    set_pins(32'h02);
    idle(3);
    rd_chk(9'h100, 32'h02, "R6 both-edge rise");
    irq_chk(32'h0, "R9 disabled line stays low");
    wr(9'h100, 32'h02);
    set_pins(32'h0);
    idle(3);
    rd_chk(9'h100, 32'h02, "R6 both-edge fall");
    wr(9'h100, 32'h02);
    rd_chk(9'h100, 32'h0, "R7 clear both-edge line");

    // R5 low level on enabled line 5
    set_pins(32'h20);
    idle(3);
    wr(cfg_ofs(5), 32'h01);
    rd_chk(9'h100, 32'h0, "R5 high pin inactive for low level");
    set_pins(32'h0);
    idle(2);
    rd_chk(9'h100, 32'h20, "R5 low level detected");
    irq_chk(32'h20, "R9 level line irq_out");
    wr(9'h100, 32'h20);
    rd_chk(9'h100, 32'h20, "R5 clear does not stick while active");
    set_pins(32'h20);
    idle(2);
    rd_chk(9'h100, 32'h0, "R5 detect follows level");
    irq_chk(32'h0, "R5 irq_out follows level");

    // R5 high level on disabled line 6
    wr(cfg_ofs(6), 32'h02);
    set_pins(32'h60);
    idle(2);
    rd_chk(9'h100, 32'h40, "R5 high level detected");
    rd_chk(9'h000, 32'h0, "R9 request view masks line 6");
    set_pins(32'h20);
    idle(2);
    rd_chk(9'h100, 32'h0, "R5 high level released");

    idle(3);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule